// File: doc/BRIEF.md
# Register-Mapped Message Queue Manager

This block holds a parameterized set of hardware FIFO queues. Each queue stores whole messages of sixteen 32-bit words. Producers and consumers reach the queues over a simple 32-bit register bus, and no message length is sent on that bus. To send, a producer writes words into a per-queue staging area. It then writes the queue's final data register, and that write pushes the complete message as one entry. To receive, a consumer reads the head message word by word. Reading the final data register returns the last word and removes the message from the queue.

Software sees each queue's occupancy in a read-only pending-count field of a per-queue state register. The same register carries a sticky flag for commits that were dropped because the queue was full. Every queue drives a level interrupt that stays asserted while the queue holds at least one message, so a consumer can service it by popping until the line drops.

Top module: `mq_msg_manager`

## Requirements
- R1: A data register's byte address is 0x80 × queue + 4 × index, with index 16..31 and proxy field (address bits 17:16) zero. Index 16+k holds message word k. A queue's state register sits at 0x20000 + 4 × queue.
- R2: A full-width write to index 16..30 stages that word. A full-width write to index 31 pushes the staged words plus the written word (as word 15) into the queue as a single entry.
- R3: Staged words not written since the previous commit are committed as zero. Staging clears after every commit, so a lone write to index 31 still pushes a message.
- R4: A read of index 16..30 returns the matching word of the head message and has no side effect. A read of index 31 returns word 15 and removes the head message.
- R5: A state register read returns the pending count in bits 23:12 and the overflow flag in bit 0. All other bits read zero.
- R6: A queue holds at most 128 messages. A commit to a full queue is dropped and sets the overflow flag. A full-width state write with bit 0 set clears the flag.
- R7: Popping an empty queue returns zero and leaves the count at zero. Head-word reads of an empty queue return zero.
- R8: A queue's interrupt is high exactly while its pending count is nonzero. It falls in the cycle after the pop that empties the queue.
- R9: An access whose byte enables are not all ones changes no staging, count or flag, and a read of that kind returns zero.
- R10: Unmapped addresses read zero and ignore writes. These include a nonzero proxy field, index below 16, queue index at or above the queue count, and unaligned or out-of-range state addresses.
- R11: Reset empties every queue, clears staging and overflow flags, and drives the interrupts and read data low.
- R12: Read data appears on the clock edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 18 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_rdata | output | 32 | Registered read data |
| queue_irq | output | NQ | Per-queue pending-message interrupt |

## Verification
The assertions assume that the bus never raises the read and write strobes in the same cycle. They also assume that a queue is never committed and popped together. One check guards the first of these, and the second follows from it because a single address reaches one register. The stimulus performs one access per bus transaction, with the strobes held for exactly one cycle and dropped between transactions. Partial-byte and unmapped accesses are issued only as separate, isolated transactions.

// File: rtl/mq_pkg.sv
package mq_pkg;
  localparam int WORD_W     = 32;
  localparam int MSG_WORDS  = 16;
  localparam int IDX_W      = 4;
  localparam int CNT_FLD_W  = 12;

  typedef struct packed {
    logic             data_hit;
    logic             state_hit;
    logic [7:0]       qsel;
    logic [IDX_W-1:0] widx;
  } mq_dec_t;
endpackage

// File: rtl/mq_addr_decode.sv
module mq_addr_decode
  import mq_pkg::*;
#(
  parameter int                NQ         = 4,
  parameter int                ADDR_W     = 18,
  parameter logic [ADDR_W-1:0] STATE_BASE = 18'h20000
) (
  input  logic [ADDR_W-1:0] addr,
  output mq_dec_t           dec
);
  logic [ADDR_W-1:0] soff;
  assign soff = addr - STATE_BASE;

  always_comb begin
    dec = '0;
    if (addr[ADDR_W-1:16] == '0 && addr[1:0] == 2'b00 && addr[6] &&
        32'(addr[15:7]) < NQ) begin
      dec.data_hit = 1'b1;
      dec.qsel     = 8'(addr[15:7]);
      dec.widx     = addr[5:2];
    end else if (addr >= STATE_BASE && soff[1:0] == 2'b00 &&
                 soff < ADDR_W'(4 * NQ)) begin
      dec.state_hit = 1'b1;
      dec.qsel      = 8'(soff[ADDR_W-1:2]);
    end
  end
endmodule

// File: rtl/mq_queue.sv
module mq_queue
  import mq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int MSG_W = WORD_W * MSG_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stage_we,
  input  logic              commit,
  input  logic              pop,
  input  logic              ovf_clr,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] head_word,
  output logic [CNT_W-1:0]  count,
  output logic              ovf,
  output logic              irq
);
  logic [MSG_W-1:0]  mem [DEPTH];
  logic [WORD_W-1:0] stg [MSG_WORDS-1];
  logic [MSG_W-1:0]  msg_in;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count_nxt;
  logic              full, empty, do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = commit & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    for (int k = 0; k < MSG_WORDS - 1; k++) msg_in[k*WORD_W +: WORD_W] = stg[k];
    msg_in[(MSG_WORDS-1)*WORD_W +: WORD_W] = wdata;
  end

  always_comb begin
    count_nxt = count;
    if (do_push && !do_pop)      count_nxt = count + CNT_W'(1);
    else if (do_pop && !do_push) count_nxt = count - CNT_W'(1);
  end

  // message storage: plain write port, no reset, so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= msg_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      irq    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      count <= count_nxt;
      irq   <= (count_nxt != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || commit) begin
      for (int k = 0; k < MSG_WORDS - 1; k++) stg[k] <= '0;
    end else if (stage_we && widx != IDX_W'(MSG_WORDS - 1)) begin
      stg[widx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 ovf <= 1'b0;
    else if (commit && full) ovf <= 1'b1;
    else if (ovf_clr)        ovf <= 1'b0;
  end

  assign head_word = empty ? '0 : mem[rd_ptr][widx*WORD_W +: WORD_W];

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  p_commit_inc_r2: assert property (@(posedge clk) disable iff (rst)
    commit && !pop && !full |=> count == $past(count) + CNT_W'(1));
  p_full_drop_r6: assert property (@(posedge clk) disable iff (rst)
    commit && !pop && full |=> count == CNT_W'(DEPTH) && ovf);
  p_pop_dec_r4: assert property (@(posedge clk) disable iff (rst)
    pop && !commit && !empty |=> count == $past(count) - CNT_W'(1));
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (rst)
    pop && !commit && empty |=> count == '0);
  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (count != '0));
endmodule

// File: rtl/mq_msg_manager.sv
module mq_msg_manager
  import mq_pkg::*;
#(
  parameter int                NQ         = 4,
  parameter int                DEPTH      = 128,
  parameter int                ADDR_W     = 18,
  parameter logic [ADDR_W-1:0] STATE_BASE = 18'h20000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NQ-1:0]     queue_irq
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int QSEL_W = (NQ > 1) ? $clog2(NQ) : 1;

  mq_dec_t           dec;
  logic              full_be, is_last;
  logic [QSEL_W-1:0] qi;
  logic [WORD_W-1:0] head [NQ];
  logic [CNT_W-1:0]  cnt  [NQ];
  logic [NQ-1:0]     ovf_v;
  logic [NQ*CNT_W-1:0] cnt_flat;

  mq_addr_decode #(.NQ(NQ), .ADDR_W(ADDR_W), .STATE_BASE(STATE_BASE)) u_dec (
    .addr(bus_addr),
    .dec (dec)
  );

  assign full_be = &bus_be;
  assign is_last = (dec.widx == IDX_W'(MSG_WORDS - 1));
  assign qi      = dec.qsel[QSEL_W-1:0];

  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic sel_d, sel_s;
    assign sel_d = dec.data_hit  && full_be && (dec.qsel == 8'(g));
    assign sel_s = dec.state_hit && full_be && (dec.qsel == 8'(g));

    mq_queue #(.DEPTH(DEPTH)) u_q (
      .clk      (clk),
      .rst      (rst),
      .stage_we (bus_wr & sel_d & ~is_last),
      .commit   (bus_wr & sel_d & is_last),
      .pop      (bus_rd & sel_d & is_last),
      .ovf_clr  (bus_wr & sel_s & bus_wdata[0]),
      .widx     (dec.widx),
      .wdata    (bus_wdata),
      .head_word(head[g]),
      .count    (cnt[g]),
      .ovf      (ovf_v[g]),
      .irq      (queue_irq[g])
    );
    assign cnt_flat[g*CNT_W +: CNT_W] = cnt[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (dec.data_hit && full_be)
        bus_rdata <= head[qi];
      else if (dec.state_hit && full_be)
        bus_rdata <= {8'h00, CNT_FLD_W'(cnt[qi]), 11'h000, ovf_v[qi]};
      else
        bus_rdata <= '0;
    end
  end

  p_single_strobe_r12: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));
  p_partial_be_r9: assert property (@(posedge clk) disable iff (rst)
    (bus_wr || bus_rd) && !full_be |=> $stable(cnt_flat) && $stable(ovf_v));
  p_partial_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !full_be |=> bus_rdata == '0);
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    bus_rd && !dec.data_hit && !dec.state_hit |=> bus_rdata == '0);
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_mq_msg_manager.sv
module tb_mq_msg_manager;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4, DEPTH = 128, NW = 16;
  localparam logic [17:0] SBASE = 18'h20000;

  logic clk = 1'b0, rst = 1'b1;
  logic [17:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_rdata;
  logic [NQ-1:0] queue_irq;

  mq_msg_manager #(.NQ(NQ), .DEPTH(DEPTH)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [511:0] fq [NQ][$];
  logic [31:0]  stg [NQ][NW];
  bit           ovf_m [NQ];

  function automatic logic [17:0] daddr(int q, int r);
    return 18'(q * 128 + r * 4);
  endfunction
  function automatic logic [17:0] saddr(int q);
    return SBASE + 18'(4 * q);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int q = 0; q < NQ; q++) begin
      fq[q].delete();
      ovf_m[q] = 0;
      for (int k = 0; k < NW; k++) stg[q][k] = '0;
    end
  endtask

  task automatic access(logic [17:0] a, bit wr, bit rd, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d; bus_be = be;
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; bus_be = 4'hF;
  endtask

  task automatic stage_write(int q, int r, logic [31:0] d);
    access(daddr(q, r), 1, 0, d, 4'hF);
    stg[q][r-16] = d;
  endtask

  task automatic commit(int q, logic [31:0] d);
    logic [511:0] e;
    access(daddr(q, 31), 1, 0, d, 4'hF);
    for (int k = 0; k < NW - 1; k++) e[k*32 +: 32] = stg[q][k];
    e[15*32 +: 32] = d;
    if (fq[q].size() < DEPTH) fq[q].push_back(e); else ovf_m[q] = 1;
    for (int k = 0; k < NW; k++) stg[q][k] = '0;
  endtask

  task automatic read_word(int q, int r, string tag);
    logic [31:0] e;
    e = (fq[q].size() != 0) ? fq[q][0][(r-16)*32 +: 32] : 32'h0;
    access(daddr(q, r), 0, 1, 32'h0, 4'hF);
    if (r == 31 && fq[q].size() != 0) void'(fq[q].pop_front());
    check(tag, bus_rdata, e);
  endtask

  task automatic read_state(int q, string tag);
    logic [31:0] e;
    e = {8'h00, 12'(fq[q].size()), 11'h000, ovf_m[q]};
    access(saddr(q), 0, 1, 32'h0, 4'hF);
    check(tag, bus_rdata, e);
  endtask

  task automatic raw_read(logic [17:0] a, logic [3:0] be, string tag);
    access(a, 0, 1, 32'h0, be);
    check(tag, bus_rdata, 32'h0);
  endtask

  // cycle-by-cycle interrupt comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NQ-1:0] e;
      for (int q = 0; q < NQ; q++) e[q] = (fq[q].size() != 0);
      check("R8 irq", 32'(queue_irq), 32'(e));
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R11: reset state
    check("R11 rdata after reset", bus_rdata, 32'h0);
    check("R11 irq after reset", 32'(queue_irq), 32'h0);
    for (int q = 0; q < NQ; q++) read_state(q, "R11 state after reset");

    // R1 R2 R4 R5: full message in queue 0
    for (int r = 16; r < 31; r++) stage_write(0, r, 32'hA000_0000 + 32'(r));
    commit(0, 32'hCAFE_F00D);
    read_state(0, "R5 count one");
    read_word(0, 16, "R4 head word 16");
    read_word(0, 23, "R1 head word 23");
    read_word(0, 30, "R4 head word 30");
    read_word(0, 30, "R4 repeat read no side effect");
    read_state(0, "R4 peek kept count");
    read_word(0, 31, "R4 pop last word");
    read_state(0, "R5 count zero");

    // R3: partial staging and lone commit
    stage_write(1, 16, 32'h1111_1111);
    stage_write(1, 17, 32'h2222_2222);
    commit(1, 32'h3333_3333);
    commit(1, 32'h4444_4444);
    read_word(1, 17, "R3 staged word");
    read_word(1, 18, "R3 unwritten word zero");
    read_word(1, 31, "R3 pop first");
    read_word(1, 16, "R3 staging cleared after commit");
    read_word(1, 31, "R3 lone commit pushed");

    // R2: FIFO order across queues
    stage_write(2, 20, 32'h0000_0020);
    commit(2, 32'h0000_0001);
    commit(3, 32'h0000_0099);
    commit(2, 32'h0000_0002);
    read_state(2, "R2 two entries");
    read_word(2, 31, "R2 first out");
    read_word(3, 31, "R2 other queue independent");
    read_word(2, 31, "R2 second out");

    // R6: capacity and overflow
    for (int i = 0; i < DEPTH; i++) commit(3, 32'(i));
    read_state(3, "R6 full count");
    commit(3, 32'hDEAD_BEEF);
    read_state(3, "R6 overflow set, count held");
    access(saddr(3), 1, 0, 32'h1, 4'h3);
    read_state(3, "R9 partial clear ignored");
    access(saddr(3), 1, 0, 32'h1, 4'hF); ovf_m[3] = 0;
    read_state(3, "R6 overflow cleared");
    for (int i = 0; i < DEPTH; i++) read_word(3, 31, "R6 drain order");

    // R7: empty queue
    read_word(3, 31, "R7 empty pop zero");
    read_word(3, 16, "R7 empty head zero");
    read_state(3, "R7 empty count");

    // R9: partial byte enables
    access(daddr(0, 31), 1, 0, 32'h5555_5555, 4'h7);
    read_state(0, "R9 partial commit ignored");
    access(daddr(0, 16), 1, 0, 32'h7777_7777, 4'hE);
    commit(0, 32'h6666_6666);
    read_word(0, 16, "R9 partial stage ignored");
    raw_read(daddr(0, 31), 4'hE, "R9 partial read zero");
    read_state(0, "R9 partial read no pop");
    raw_read(saddr(0), 4'h1, "R9 partial state read zero");

    // R10: unmapped
    raw_read(daddr(0, 3), 4'hF, "R10 low index");
    raw_read(daddr(NQ, 16), 4'hF, "R10 queue beyond count");
    raw_read(18'h10000 + daddr(0, 16), 4'hF, "R10 proxy one");
    raw_read(saddr(NQ), 4'hF, "R10 state beyond count");
    raw_read(SBASE + 18'd1, 4'hF, "R10 unaligned state");
    access(18'h10000 + daddr(0, 31), 1, 0, 32'h1, 4'hF);
    access(daddr(NQ, 31), 1, 0, 32'h1, 4'hF);
    for (int q = 0; q < NQ; q++) read_state(q, "R10 writes ignored");

    // R11: reset mid-traffic
    commit(1, 32'h1234_5678);
    @(negedge clk); rst = 1;
    @(posedge clk); #1; model_clear();
    @(negedge clk); rst = 0;
    check("R11 irq cleared", 32'(queue_irq), 32'h0);
    read_state(1, "R11 queue emptied");
    read_word(1, 31, "R11 no stale message");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule